// File: doc/BRIEF.md
# Serial-bus wiper controller with command byte

This block is a two-wire serial-bus slave that owns the settings of four 256-step wiper channels. It is active when the interface-select input is 1. It holds an 8-bit code and a shutdown flag for each channel, and it drives two general-purpose output pins. A bus master addresses the slave with a 7-bit address. The upper five bits of that address are fixed. The lower two bits come from strap pins.

A write has three bytes. The first is the address byte. The second is a command byte, which picks a channel and carries reset-to-mid-scale, shutdown and output-pin bits. The third is the data byte, which holds the new code. A read returns the code of the channel named by the most recent command byte.

The SDA pad is open-drain and is shown as a pull-low enable. SCL and SDA are brought into the system clock domain through a synchronizer. All bus events are then found from edges of the synchronized lines. A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high.

Top module: `i2c_wiper_ctrl`

## Requirements
- R1: After reset, every channel code is 0x80, all shutdown flags are 0, both output pins are 0 and SDA is released.
- R2: After a START, the slave acknowledges an address byte whose bits 7..3 are 01011 and whose bits 2..1 equal adr_strap[1:0]. Bit 0 = 0 selects a write and bit 0 = 1 selects a read.
- R3: In a write, the byte after the address is a command byte and is acknowledged. Bits 7..6 hold the channel number, bit 5 is reset, bit 4 is shutdown, bit 3 is output 1 and bit 2 is output 2.
- R4: When the command reset bit is 0, the acknowledged data byte becomes the code of the selected channel. The other channels are unchanged. Channel n appears on wiper_codes[8n+7:8n].
- R5: When the address does not match, the slave gives no acknowledge. It then ignores every following byte, without acknowledging and without any state change, until the next START.
- R6: When the command reset bit is 1, the selected channel code becomes 0x80. The data byte that follows is acknowledged and discarded.
- R7: Each command byte writes its shutdown bit to shut_dn of the selected channel only, and channel codes are kept. A channel leaves shutdown only through a command to that same channel with the bit at 0.
- R8: Each acknowledged command byte sets gp_out[0] to its bit 3 and gp_out[1] to its bit 2.
- R9: A read sends the code of the channel named by the most recent command byte, MSB first. That channel is kept across transactions. SDA is released for the master's acknowledge.
- R10: A repeated START restarts address reception. A command byte can therefore be followed at once by a read address.
- R11: In a write, any byte after the data byte is not acknowledged and changes nothing.
- R12: While iface_sel is 0, the slave ignores the bus and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| iface_sel | input | 1 | 1 enables the two-wire slave |
| scl | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| adr_strap | input | 2 | Low two bits of the slave address |
| wiper_codes | output | 32 | Four 8-bit channel codes, channel 0 lowest |
| shut_dn | output | 4 | Per-channel shutdown flags |
| gp_out | output | 2 | General-purpose output pins |

## Verification
The bench builds the block with SYNC_LEN at 3 rather than the default 2. Every acknowledge and read bit therefore goes through a deeper synchronizer than the default, while the bus quarter period still gives ample margin. It drives the strap pins with 01 and sends an address with straps 10, so both the match path and the mismatch path are reached. A repeated START that follows a command byte covers the case where a read takes its channel from a command that carried no data.

// File: rtl/i2c_wiper_ctrl.sv
`timescale 1ns/1ps
module i2c_wiper_ctrl #(
  parameter int         SYNC_LEN = 2,
  parameter logic [4:0] ADDR_HI  = 5'b01011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        iface_sel,
  input  logic        scl,
  input  logic        sda_in,
  output logic        sda_oe,
  input  logic [1:0]  adr_strap,
  output logic [31:0] wiper_codes,
  output logic [3:0]  shut_dn,
  output logic [1:0]  gp_out
);
  localparam logic [7:0] MID = 8'h80;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_INSTR, S_DATA, S_READ, S_SKIP} st_t;

  logic [SYNC_LEN-1:0] scl_sr, sda_sr;
  logic       scl_s, sda_s, scl_d, sda_d;
  logic       scl_rise, scl_fall, start_c, stop_c;
  st_t        state, nxt;
  logic [7:0] sh, tx;
  logic [3:0] cnt;
  logic       in_ack, rs_q;
  logic [1:0] sel;
  logic [3:0][7:0] wip;

  assign scl_s    = scl_sr[SYNC_LEN-1];
  assign sda_s    = sda_sr[SYNC_LEN-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  assign wiper_codes = wip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_LEN-2:0], scl};
      sda_sr <= {sda_sr[SYNC_LEN-2:0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      nxt     <= S_IDLE;
      sh      <= '0;
      tx      <= '0;
      cnt     <= '0;
      in_ack  <= 1'b0;
      rs_q    <= 1'b0;
      sel     <= '0;
      sda_oe  <= 1'b0;
      wip     <= {4{MID}};
      shut_dn <= '0;
      gp_out  <= '0;
    end else if (!iface_sel) begin
      state  <= S_IDLE;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_c) begin
      state  <= S_ADDR;
      cnt    <= '0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state  <= S_IDLE;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (state != S_IDLE && state != S_SKIP) begin
      if (scl_rise && !in_ack && cnt < 4'd8) begin
        sh  <= {sh[6:0], sda_s};
        cnt <= cnt + 4'd1;
      end
      if (scl_fall) begin
        if (in_ack) begin
          in_ack <= 1'b0;
          cnt    <= '0;
          state  <= nxt;
          sda_oe <= (nxt == S_READ) ? ~wip[sel][7] : 1'b0;
          tx     <= {wip[sel][6:0], 1'b0};
        end else if (state == S_READ) begin
          if (cnt < 4'd8) begin
            sda_oe <= ~tx[7];
            tx     <= {tx[6:0], 1'b0};
          end else begin
            sda_oe <= 1'b0;
            state  <= S_SKIP;
          end
        end else if (cnt == 4'd8) begin
          case (state)
            S_ADDR: begin
              if (sh[7:1] == {ADDR_HI, adr_strap}) begin
                sda_oe <= 1'b1;
                in_ack <= 1'b1;
                nxt    <= sh[0] ? S_READ : S_INSTR;
              end else begin
                state <= S_SKIP;
              end
            end
            S_INSTR: begin
              sel              <= sh[7:6];
              rs_q             <= sh[5];
              shut_dn[sh[7:6]] <= sh[4];
              gp_out           <= {sh[2], sh[3]};
              if (sh[5]) wip[sh[7:6]] <= MID;
              sda_oe <= 1'b1;
              in_ack <= 1'b1;
              nxt    <= S_DATA;
            end
            S_DATA: begin
              if (!rs_q) wip[sel] <= sh;
              sda_oe <= 1'b1;
              in_ack <= 1'b1;
              nxt    <= S_SKIP;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

module wiper_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        iface_sel,
  input logic        scl_s,
  input logic        scl_fall,
  input logic        sda_oe,
  input logic [31:0] wiper_codes,
  input logic [3:0]  shut_dn,
  input logic [1:0]  gp_out
);
  p_release_when_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !iface_sel |=> !sda_oe);

  p_code_moves_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper_codes) |-> $past(scl_fall));

  p_one_shutdown_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(shut_dn ^ $past(shut_dn)) <= 1);

  p_pins_move_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gp_out) |-> $past(scl_fall));

  p_sda_moves_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iface_sel && $past(iface_sel) && !$stable(sda_oe)) |-> !$past(scl_s));
endmodule

bind i2c_wiper_ctrl wiper_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .iface_sel(iface_sel), .scl_s(scl_s),
  .scl_fall(scl_fall), .sda_oe(sda_oe), .wiper_codes(wiper_codes),
  .shut_dn(shut_dn), .gp_out(gp_out)
);

// File: tb/sim_i2c_wiper_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_wiper_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, iface_sel = 1'b1, scl = 1'b1, m_low = 1'b0;
  logic [1:0]  adr_strap = 2'b01;
  logic        sda_oe;
  logic [31:0] wiper_codes;
  logic [3:0]  shut_dn;
  logic [1:0]  gp_out;
  wire sda_bus = (m_low | sda_oe) ? 1'b0 : 1'b1;

  always #10 clk = ~clk;

  i2c_wiper_ctrl #(.SYNC_LEN(3)) u0 (
    .clk(clk), .rst_n(rst_n), .iface_sel(iface_sel), .scl(scl), .sda_in(sda_bus),
    .sda_oe(sda_oe), .adr_strap(adr_strap), .wiper_codes(wiper_codes),
    .shut_dn(shut_dn), .gp_out(gp_out));

  typedef struct { string req; longint val; } item_t;
  item_t  q[$];
  longint obs;
  event   ev;
  int     errors = 0, checks = 0;
  localparam time Q = 200;

  always @(ev) begin
    item_t it;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL scoreboard empty: actual %0h expected none", obs);
    end else begin
      it = q.pop_front();
      if (obs !== it.val) begin
        errors++;
        $display("FAIL %s: actual %0h expected %0h", it.req, obs, it.val);
      end
    end
  end

  task automatic expect_val(input string r, input longint e, input longint o);
    q.push_back('{r, e});
    obs = o;
    ->ev;
    #1;
  endtask

  task automatic bus_start();
    m_low = 1'b0; #Q; scl = 1'b1; #Q; m_low = 1'b1; #Q; scl = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    m_low = 1'b1; #Q; scl = 1'b1; #Q; m_low = 1'b0; #Q;
  endtask

  task automatic put_bit(input logic b);
    m_low = ~b; #Q; scl = 1'b1; #Q; #Q; scl = 1'b0; #Q;
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0; #Q; scl = 1'b1; #Q; b = sda_bus; #Q; scl = 1'b0; #Q;
  endtask

  task automatic send(input logic [7:0] b, input int exp_ack, input string r);
    logic nb;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(nb);
    expect_val(r, exp_ack, {63'd0, ~nb});
  endtask

  task automatic recv(input logic [7:0] e, input string r);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(1'b1);
    expect_val(r, e, v);
  endtask

  function automatic logic [7:0] cmd(input int ch, input bit rs, input bit sd, input bit o1, input bit o2);
    return {ch[1:0], rs, sd, o1, o2, 2'b00};
  endfunction

  task automatic wr(input int ch, input bit rs, input bit sd, input bit o1, input bit o2,
                    input logic [7:0] d, input int ack, input string r);
    bus_start();
    send(8'h5A, ack, r);
    send(cmd(ch, rs, sd, o1, o2), ack, r);
    send(d, ack, r);
    bus_stop();
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #Q;
    expect_val("R1 codes", 32'h80808080, wiper_codes);
    expect_val("R1 shutdown", 0, shut_dn);
    expect_val("R1 pins", 0, gp_out);
    expect_val("R1 sda", 0, sda_oe);

    wr(2, 0, 0, 0, 0, 8'h3C, 1, "R2 R3 R4 ack");
    expect_val("R4 write ch2", 32'h803C8080, wiper_codes);

    bus_start();
    send(8'h5A, 1, "R2 ack");
    send(cmd(0, 0, 0, 0, 0), 1, "R3 ack");
    send(8'h12, 1, "R4 ack");
    send(8'hFF, 0, "R11 extra byte nack");
    bus_stop();
    expect_val("R11 codes", 32'h803C8012, wiper_codes);

    bus_start();
    send(8'h5C, 0, "R5 address nack");
    send(cmd(0, 0, 1, 1, 1), 0, "R5 ignored");
    send(8'h99, 0, "R5 ignored");
    bus_stop();
    expect_val("R5 codes", 32'h803C8012, wiper_codes);
    expect_val("R5 shutdown", 0, shut_dn);
    expect_val("R5 pins", 0, gp_out);

    wr(2, 1, 0, 0, 0, 8'h11, 1, "R6 ack");
    expect_val("R6 mid-scale", 32'h80808012, wiper_codes);

    wr(1, 0, 1, 0, 0, 8'h55, 1, "R7 ack");
    expect_val("R7 shutdown ch1", 4'b0010, shut_dn);
    expect_val("R7 codes", 32'h80805512, wiper_codes);
    wr(3, 0, 1, 0, 0, 8'h77, 1, "R7 ack");
    expect_val("R7 shutdown ch3", 4'b1010, shut_dn);
    wr(1, 0, 0, 0, 0, 8'h55, 1, "R7 ack");
    expect_val("R7 exit ch1", 4'b1000, shut_dn);
    expect_val("R7 codes kept", 32'h77805512, wiper_codes);

    wr(0, 0, 0, 1, 0, 8'h12, 1, "R8 ack");
    expect_val("R8 pins 01", 2'b01, gp_out);

    bus_start();
    send(8'h5A, 1, "R10 ack");
    send(cmd(3, 0, 1, 0, 1), 1, "R10 ack");
    bus_start();
    send(8'h5B, 1, "R10 read address ack");
    recv(8'h77, "R9 read ch3");
    bus_stop();
    expect_val("R8 pins 10", 2'b10, gp_out);
    expect_val("R9 sda released", 0, sda_oe);

    bus_start();
    send(8'h5B, 1, "R2 read ack");
    recv(8'h77, "R9 read keeps channel");
    bus_stop();

    iface_sel = 1'b0;
    #Q;
    wr(0, 0, 0, 0, 0, 8'hAA, 0, "R12 nack");
    expect_val("R12 codes", 32'h77805512, wiper_codes);
    expect_val("R12 sda", 0, sda_oe);

    #Q;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule